// File: doc/BRIEF.md
# Data Cache Line Maintenance Unit

This block carries out single-line maintenance requests against a direct-mapped data cache tag store that it owns. Each request supplies two 32-bit operands, three control flags and a user-mode indication. The block forms the target address and splits it into tag, line index and offset. Depending on the cache policy and the flags, it then does one of three things:

- it drops the line;
- it writes a dirty line out through a writeback handshake and then drops it;
- it forwards an invalidate or flush request to an external cache.

A protected-mode check can turn a request into a privileged-operation exception. Every request ends with one `done` pulse.

The cache side of the pipeline fills lines through a fill port, which records the tag and, in write-back mode, a dirty mark. It checks residency through a lookup port. These two ports are how the maintenance results become visible.

The address of a line is built as {tag, index, offset}. The offset width is 4 bits for 4-word lines and 5 bits for 8-word lines. The index width is log2(cache bytes) minus the offset width, and the tag takes the remaining upper bits.

Top module: `dcache_maint`

## Requirements
- R1: With WRITEBACK=1 the target address is op_a + op_b (32-bit wraparound sum). With WRITEBACK=0 the target is op_a alone, and op_b has no effect.
- R2: The line index is target[OFF_W+IDX_W-1:OFF_W], with OFF_W=4 for LINE_WORDS=4 and OFF_W=5 for LINE_WORDS=8. Any address the block presents has its low OFF_W bits zero.
- R3: In write-back mode, a request with flush_sel=1 that selects a valid dirty line raises wb_valid with wb_addr = {stored tag, index, zeros}. It holds both stable until wb_ready, then clears the line's valid and dirty bits.
- R4: In write-back mode with flush_sel=0, a selected line is dropped with no writeback, even when it is dirty. A flush of a clean or invalid line also performs no writeback.
- R5: With match_only=1, a line is selected only when it is valid and its stored tag equals the target tag. Otherwise the line is left unchanged. With match_only=0, the indexed line is always selected.
- R6: In write-through mode with ext_sel=0, the selected local line is invalidated. In write-back mode ext_sel has no effect.
- R7: In write-through mode with ext_sel=1 and EXT_COHERENT=1, the block raises ext_valid with ext_addr set to the line-aligned target and ext_flush equal to flush_sel. It holds them until ext_ready, and the local line is untouched.
- R8: With USE_MMU=1 and user_mode=1, the request changes no line and raises no writeback or external request. It pulses exc for one cycle, with exc_code = 5'b00111.
- R9: Each accepted request produces exactly one single-cycle done pulse. For an excepted request, done is high in the cycle after the request edge. For a local operation without writeback, done is high one cycle later than that. Requests are taken only while idle.
- R10: A fill (taken while idle with no request) marks the indexed line valid with the address tag. It also marks the line dirty only in write-back mode. A lookup returns lk_hit and lk_dirty in the cycle after lk_addr is presented, and a dirty line is always valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Maintenance request strobe |
| op_a | input | 32 | First address operand |
| op_b | input | 32 | Second address operand (write-back mode only) |
| ext_sel | input | 1 | Route to external cache (write-through mode) |
| flush_sel | input | 1 | Flush rather than discard |
| match_only | input | 1 | Act only on a tag match |
| user_mode | input | 1 | Requester runs unprivileged |
| done | output | 1 | Request completion pulse |
| exc | output | 1 | Privileged-operation exception pulse |
| exc_code | output | 5 | Exception code |
| wb_valid | output | 1 | Line writeback request |
| wb_addr | output | 32 | Line-aligned writeback address |
| wb_ready | input | 1 | Writeback acknowledge |
| ext_valid | output | 1 | External cache request |
| ext_addr | output | 32 | Line-aligned external address |
| ext_flush | output | 1 | External request is a flush |
| ext_ready | input | 1 | External request acknowledge |
| fill_valid | input | 1 | Line fill strobe |
| fill_addr | input | 32 | Fill address |
| fill_dirty | input | 1 | Filled line is dirty |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_dirty | output | 1 | Lookup line is dirty |

## Verification
Two instances are driven: a write-back one and a write-through one.

Directed operands include:
- a sum that carries across the index field, which tells addition from first-operand use;
- a large second operand in write-through mode, which exposes any wrong use of it.

Tag-mismatch requests with match_only set separate a real tag compare from index-only selection. Flushes of clean and dirty lines separate the writeback path from plain invalidation.

Random requests drawn from three tags and four indices give frequent hits, misses and evictions across all flag combinations. A bench model predicts the writeback and external addresses, the exceptions and the latencies, and follow-up lookups reveal the line state each request leaves behind.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_WB,
    ST_EXT
  } dcm_state_e;

  localparam logic [4:0] EXC_PRIV = 5'b00111;

  function automatic int off_bits(input int line_words);
    return $clog2(line_words * 4);
  endfunction
endpackage

// File: rtl/dcm_addr_split.sv
module dcm_addr_split #(
  parameter int OFF_W = 4,
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic [TAG_W+IDX_W-1:0] upper,
  output logic [IDX_W-1:0]       idx,
  output logic [TAG_W-1:0]       tag
);
  assign idx = upper[IDX_W-1:0];
  assign tag = upper[TAG_W+IDX_W-1:IDX_W];
endmodule

// File: rtl/dcm_tag_store.sv
module dcm_tag_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic             rd_valid,
  output logic             rd_dirty,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [TAG_W-1:0] lk_tag,
  output logic             lk_valid,
  output logic             lk_dirty,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_dirty,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [LINES];
  logic [LINES-1:0] valid_r;
  logic [LINES-1:0] dirty_r;

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
    lk_tag <= tag_mem[lk_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r  <= '0;
      dirty_r  <= '0;
      rd_valid <= 1'b0;
      rd_dirty <= 1'b0;
      lk_valid <= 1'b0;
      lk_dirty <= 1'b0;
    end else begin
      if (wr_en) begin
        valid_r[wr_idx] <= 1'b1;
        dirty_r[wr_idx] <= wr_dirty;
      end
      if (clr_en) begin
        valid_r[clr_idx] <= 1'b0;
        dirty_r[clr_idx] <= 1'b0;
      end
      if (rd_en) begin
        rd_valid <= valid_r[rd_idx];
        rd_dirty <= dirty_r[rd_idx];
      end
      lk_valid <= valid_r[lk_idx];
      lk_dirty <= dirty_r[lk_idx];
    end
  end

  assert_dirty_needs_valid_R10: assert property (@(posedge clk) disable iff (rst)
    (dirty_r & ~valid_r) == '0);
  assert_no_fill_during_clear_R10: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && clr_en));
endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
  import dcm_pkg::*;
#(
  parameter int IDX_W        = 6,
  parameter int TAG_W        = 22,
  parameter int OFF_W        = 4,
  parameter bit WRITEBACK    = 1'b1,
  parameter bit USE_MMU      = 1'b1,
  parameter bit EXT_COHERENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic [TAG_W-1:0] tgt_tag,
  input  logic             ext_sel,
  input  logic             flush_sel,
  input  logic             match_only,
  input  logic             user_mode,
  output logic             rd_en,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             rd_valid,
  input  logic             rd_dirty,
  output logic             clr_en,
  output logic [IDX_W-1:0] clr_idx,
  output logic             fill_ok,
  output logic             done,
  output logic             exc,
  output logic [4:0]       exc_code,
  output logic             wb_valid,
  output logic [31:0]      wb_addr,
  input  logic             wb_ready,
  output logic             ext_valid,
  output logic [31:0]      ext_addr,
  output logic             ext_flush,
  input  logic             ext_ready
);
  dcm_state_e       state;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic             flush_q, match_q;
  logic             hit, sel, start_wb;

  assign hit      = rd_valid && (rd_tag == tag_q);
  assign sel      = match_q ? hit : 1'b1;
  assign start_wb = WRITEBACK && flush_q && sel && rd_valid && rd_dirty;
  assign rd_en    = (state == ST_IDLE) && req;
  assign fill_ok  = (state == ST_IDLE) && !req;
  assign clr_idx  = idx_q;
  assign clr_en   = ((state == ST_DECIDE) && sel && !start_wb) ||
                    ((state == ST_WB) && wb_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      idx_q     <= '0;
      tag_q     <= '0;
      flush_q   <= 1'b0;
      match_q   <= 1'b0;
      done      <= 1'b0;
      exc       <= 1'b0;
      exc_code  <= '0;
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      ext_valid <= 1'b0;
      ext_addr  <= '0;
      ext_flush <= 1'b0;
    end else begin
      done <= 1'b0;
      exc  <= 1'b0;
      case (state)
        ST_IDLE: if (req) begin
          idx_q   <= tgt_idx;
          tag_q   <= tgt_tag;
          flush_q <= flush_sel;
          match_q <= match_only;
          if (USE_MMU && user_mode) begin
            done     <= 1'b1;
            exc      <= 1'b1;
            exc_code <= EXC_PRIV;
          end else if (!WRITEBACK && ext_sel) begin
            if (EXT_COHERENT) begin
              ext_valid <= 1'b1;
              ext_addr  <= {tgt_tag, tgt_idx, {OFF_W{1'b0}}};
              ext_flush <= flush_sel;
              state     <= ST_EXT;
            end else begin
              done <= 1'b1;
            end
          end else begin
            state <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (start_wb) begin
            wb_valid <= 1'b1;
            wb_addr  <= {rd_tag, idx_q, {OFF_W{1'b0}}};
            state    <= ST_WB;
          end else begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_WB: if (wb_ready) begin
          wb_valid <= 1'b0;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_EXT: if (ext_ready) begin
          ext_valid <= 1'b0;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_wb_hold_R3: assert property (@(posedge clk) disable iff (rst)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
  assert_wb_from_dirty_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_valid) |-> $past(rd_dirty) && $past(flush_q));
  assert_ext_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ext_valid && !ext_ready |=> ext_valid && $stable(ext_addr) && $stable(ext_flush));
  assert_exc_code_R8: assert property (@(posedge clk) disable iff (rst)
    exc |-> exc_code == EXC_PRIV && done && !wb_valid && !ext_valid);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_no_wb_and_ext_R4: assert property (@(posedge clk) disable iff (rst)
    !(wb_valid && ext_valid));
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
  import dcm_pkg::*;
#(
  parameter bit WRITEBACK    = 1'b1,
  parameter int LINE_WORDS   = 4,
  parameter int CACHE_BYTES  = 1024,
  parameter bit USE_MMU      = 1'b1,
  parameter bit EXT_COHERENT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic        ext_sel,
  input  logic        flush_sel,
  input  logic        match_only,
  input  logic        user_mode,
  output logic        done,
  output logic        exc,
  output logic [4:0]  exc_code,
  output logic        wb_valid,
  output logic [31:0] wb_addr,
  input  logic        wb_ready,
  output logic        ext_valid,
  output logic [31:0] ext_addr,
  output logic        ext_flush,
  input  logic        ext_ready,
  input  logic        fill_valid,
  input  logic [31:0] fill_addr,
  input  logic        fill_dirty,
  input  logic [31:0] lk_addr,
  output logic        lk_hit,
  output logic        lk_dirty
);
  localparam int OFF_W = off_bits(LINE_WORDS);
  localparam int IDX_W = $clog2(CACHE_BYTES) - OFF_W;
  localparam int TAG_W = 32 - IDX_W - OFF_W;

  logic [31:0]      tgt;
  logic [IDX_W-1:0] tgt_idx, fill_idx, lk_idx, clr_idx;
  logic [TAG_W-1:0] tgt_tag, fill_tag, lk_tag, lk_tag_q, rd_tag, lk_tag_rd;
  logic             rd_en, rd_valid, rd_dirty, clr_en, fill_ok;
  logic             lk_valid_rd, lk_dirty_rd;

  generate
    if (WRITEBACK) begin : g_sum
      assign tgt = op_a + op_b;
    end else begin : g_single
      assign tgt = op_a;
    end
  endgenerate

  dcm_addr_split #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_tgt (
    .upper(tgt[31:OFF_W]), .idx(tgt_idx), .tag(tgt_tag));
  dcm_addr_split #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_fill (
    .upper(fill_addr[31:OFF_W]), .idx(fill_idx), .tag(fill_tag));
  dcm_addr_split #(.OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_split_lk (
    .upper(lk_addr[31:OFF_W]), .idx(lk_idx), .tag(lk_tag));

  dcm_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_idx(tgt_idx), .rd_tag(rd_tag),
    .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .lk_idx(lk_idx), .lk_tag(lk_tag_rd), .lk_valid(lk_valid_rd), .lk_dirty(lk_dirty_rd),
    .wr_en(fill_valid && fill_ok), .wr_idx(fill_idx), .wr_tag(fill_tag),
    .wr_dirty(WRITEBACK && fill_dirty),
    .clr_en(clr_en), .clr_idx(clr_idx));

  dcm_ctrl #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W),
    .WRITEBACK(WRITEBACK), .USE_MMU(USE_MMU), .EXT_COHERENT(EXT_COHERENT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .req(req),
    .tgt_idx(tgt_idx), .tgt_tag(tgt_tag),
    .ext_sel(ext_sel), .flush_sel(flush_sel), .match_only(match_only),
    .user_mode(user_mode),
    .rd_en(rd_en), .rd_tag(rd_tag), .rd_valid(rd_valid), .rd_dirty(rd_dirty),
    .clr_en(clr_en), .clr_idx(clr_idx), .fill_ok(fill_ok),
    .done(done), .exc(exc), .exc_code(exc_code),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_ready(wb_ready),
    .ext_valid(ext_valid), .ext_addr(ext_addr), .ext_flush(ext_flush),
    .ext_ready(ext_ready));

  always_ff @(posedge clk) begin
    if (rst) lk_tag_q <= '0;
    else     lk_tag_q <= lk_tag;
  end

  assign lk_hit   = lk_valid_rd && (lk_tag_rd == lk_tag_q);
  assign lk_dirty = lk_hit && lk_dirty_rd;

  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (wb_valid |-> wb_addr[OFF_W-1:0] == '0) and (ext_valid |-> ext_addr[OFF_W-1:0] == '0));
endmodule

// File: tb/dcache_maint_bench.sv
module dcache_maint_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic [1:0]  req, wb_ready, ext_ready;
  logic [31:0] op_a, op_b, fill_addr, lk_addr;
  logic        ext_sel, flush_sel, match_only, user_mode, fill_valid, fill_dirty;
  logic [1:0]  done, exc, wb_valid, ext_valid, ext_flush, lk_hit, lk_dirty;
  logic [4:0]  exc_code [2];
  logic [31:0] wb_addr [2];
  logic [31:0] ext_addr [2];

  int checks = 0;
  int errors = 0;

  bit          m_v [2][64];
  bit          m_d [2][64];
  logic [21:0] m_t [2][64];

  dcache_maint #(.WRITEBACK(1'b1)) u_dcache_maint (
    .clk(clk), .rst(rst), .req(req[0]), .op_a(op_a), .op_b(op_b),
    .ext_sel(ext_sel), .flush_sel(flush_sel), .match_only(match_only), .user_mode(user_mode),
    .done(done[0]), .exc(exc[0]), .exc_code(exc_code[0]),
    .wb_valid(wb_valid[0]), .wb_addr(wb_addr[0]), .wb_ready(wb_ready[0]),
    .ext_valid(ext_valid[0]), .ext_addr(ext_addr[0]), .ext_flush(ext_flush[0]),
    .ext_ready(ext_ready[0]),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
    .lk_addr(lk_addr), .lk_hit(lk_hit[0]), .lk_dirty(lk_dirty[0]));

  dcache_maint #(.WRITEBACK(1'b0)) u_wt (
    .clk(clk), .rst(rst), .req(req[1]), .op_a(op_a), .op_b(op_b),
    .ext_sel(ext_sel), .flush_sel(flush_sel), .match_only(match_only), .user_mode(user_mode),
    .done(done[1]), .exc(exc[1]), .exc_code(exc_code[1]),
    .wb_valid(wb_valid[1]), .wb_addr(wb_addr[1]), .wb_ready(wb_ready[1]),
    .ext_valid(ext_valid[1]), .ext_addr(ext_addr[1]), .ext_flush(ext_flush[1]),
    .ext_ready(ext_ready[1]),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
    .lk_addr(lk_addr), .lk_hit(lk_hit[1]), .lk_dirty(lk_dirty[1]));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd_addr();
    logic [31:0] t;
    case ($urandom % 3)
      0: t = 32'h0000_0001;
      1: t = 32'h0000_02A5;
      default: t = 32'h003F_FFFF;
    endcase
    return (t << 10) | (($urandom % 4) << 4) | ($urandom % 16);
  endfunction

  task automatic do_fill(input logic [31:0] a, input bit d);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_dirty = d;
    @(negedge clk);
    fill_valid = 1'b0;
    for (int k = 0; k < 2; k++) begin
      m_v[k][a[9:4]] = 1'b1;
      m_t[k][a[9:4]] = a[31:10];
      m_d[k][a[9:4]] = (k == 0) ? d : 1'b0;
    end
  endtask

  task automatic do_lookup(input int k, input logic [31:0] a, input string r);
    bit eh;
    @(negedge clk);
    lk_addr = a;
    @(negedge clk);
    eh = m_v[k][a[9:4]] && (m_t[k][a[9:4]] == a[31:10]);
    chk(r, lk_hit[k], eh);
    chk(r, lk_dirty[k], eh && m_d[k][a[9:4]]);
  endtask

  task automatic do_op(input int k, input logic [31:0] a, input logic [31:0] b,
                       input bit e, input bit f, input bit t, input bit u, input string rin);
    logic [31:0] addr, ewba, wba, exa;
    logic [5:0]  idx;
    bit          sel, ewb, eext, saw_wb, saw_ext, saw_exc, got_done, exf;
    int          n, exp_n;
    logic [4:0]  code;
    string       r;
    addr = (k == 0) ? a + b : a;
    idx  = addr[9:4];
    sel  = t ? (m_v[k][idx] && m_t[k][idx] == addr[31:10]) : 1'b1;
    ewb  = 1'b0; eext = 1'b0; ewba = '0;
    if (!u) begin
      if (k == 1 && e) eext = 1'b1;
      else if (k == 0 && f && sel && m_v[k][idx] && m_d[k][idx]) begin
        ewb  = 1'b1;
        ewba = {m_t[k][idx], idx, 4'h0};
      end
    end
    exp_n = (ewb || eext) ? 0 : (u ? 1 : 2);
    if (rin != "") r = rin;
    else if (u) r = "R8";
    else if (k == 1 && e) r = "R7";
    else if (t) r = "R5";
    else if (f) r = "R3";
    else r = "R4";

    @(negedge clk);
    op_a = a; op_b = b; ext_sel = e; flush_sel = f; match_only = t; user_mode = u;
    req[k] = 1'b1;
    @(negedge clk);
    req[k] = 1'b0;
    n = 1; got_done = 0; saw_wb = 0; saw_ext = 0; saw_exc = 0;
    wba = '0; exa = '0; exf = 0; code = '0;
    while (!got_done && n < 40) begin
      wb_ready[k] = 1'b0; ext_ready[k] = 1'b0;
      if (exc[k]) begin saw_exc = 1; code = exc_code[k]; end
      if (done[k]) got_done = 1;
      else begin
        if (wb_valid[k]) begin
          if (!saw_wb) begin saw_wb = 1; wba = wb_addr[k]; end
          else chk("R3", wb_addr[k], wba);
          if ($urandom % 2) wb_ready[k] = 1'b1;
        end
        if (ext_valid[k]) begin
          if (!saw_ext) begin saw_ext = 1; exa = ext_addr[k]; exf = ext_flush[k]; end
          if ($urandom % 2) ext_ready[k] = 1'b1;
        end
        @(negedge clk);
        n++;
      end
    end
    chk({r, " done"}, got_done, 1'b1);
    chk("R8", saw_exc, u);
    if (saw_exc) chk("R8", code, 5'b00111);
    chk({r, " wb"}, saw_wb, ewb);
    if (ewb) chk("R3", wba, ewba);
    chk({r, " ext"}, saw_ext, eext);
    if (eext) begin
      chk("R7", exa, addr & 32'hFFFF_FFF0);
      chk("R7", exf, f);
    end
    if (exp_n != 0) chk("R9 latency", n, exp_n);
    @(negedge clk);
    chk("R9 pulse", done[k], 1'b0);
    if (!u && !eext && sel) begin
      m_v[k][idx] = 1'b0;
      m_d[k][idx] = 1'b0;
    end
    do_lookup(k, addr, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req = '0; wb_ready = '0; ext_ready = '0;
    op_a = '0; op_b = '0; ext_sel = 0; flush_sel = 0; match_only = 0; user_mode = 0;
    fill_valid = 0; fill_addr = '0; fill_dirty = 0; lk_addr = '0;
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < 64; i++) begin m_v[k][i] = 0; m_d[k][i] = 0; m_t[k][i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9 reset done", done, 2'b00);
    chk("R3 reset wb", wb_valid, 2'b00);
    chk("R7 reset ext", ext_valid, 2'b00);
    do_lookup(0, 32'h0, "R10 reset");
    do_lookup(1, 32'h0, "R10 reset");

    do_fill(32'h0000_0410, 1'b1);
    do_lookup(0, 32'h0000_0410, "R10");
    do_lookup(1, 32'h0000_0410, "R10");
    do_op(0, 32'h0000_03FF, 32'h0000_0013, 0, 1, 1, 0, "R1");
    do_fill(32'h0000_0410, 1'b1);
    do_op(0, 32'h0000_0414, 32'h0, 0, 0, 0, 0, "R4");
    do_fill(32'h0000_0410, 1'b1);
    do_op(0, 32'h0000_0810, 32'h0, 0, 1, 1, 0, "R5");
    do_lookup(0, 32'h0000_0410, "R5");
    do_op(0, 32'h0000_0410, 32'h0, 0, 1, 0, 1, "R8");
    do_lookup(0, 32'h0000_0410, "R8");
    do_op(0, 32'h0000_0410, 32'h0, 1, 1, 0, 0, "R6");
    do_fill(32'h0000_0410, 1'b0);
    do_op(0, 32'h0000_0410, 32'h0, 0, 1, 0, 0, "R4");
    do_fill(32'h0000_0410, 1'b1);
    do_op(1, 32'h0000_0410, 32'hFFFF_0000, 0, 0, 1, 0, "R1");
    do_fill(32'h0000_0410, 1'b0);
    do_op(1, 32'h0000_041C, 32'h0, 1, 1, 0, 0, "R7");
    do_op(1, 32'h0000_041C, 32'h1234_0000, 1, 0, 0, 0, "R2");
    do_op(1, 32'h0000_0418, 32'h0, 0, 1, 0, 0, "R6");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] tg, b;
      k  = $urandom % 2;
      tg = rnd_addr();
      if ($urandom % 3 == 0) do_fill(tg, $urandom % 2);
      else begin
        b = $urandom;
        do_op(k, (k == 0) ? tg - b : tg, b, $urandom % 2, $urandom % 2,
              $urandom % 2, ($urandom % 8) == 0, "");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule